// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models a parallel NOR flash device that speaks the common two-cycle command protocol. A host reaches it through a plain synchronous memory port: byte address, 32-bit write data, an access size of 1, 2 or 4 bytes, a write strobe and a read strobe. Writes are decoded as command bytes by a small write-state machine. Reads return array data, the 8-bit status byte, identification codes or query table bytes, depending on the command last latched. Program and erase complete in the cycle of the write that carries them. The device has no busy period, so the ready bit is set as soon as an operation is accepted.

The write-state machine has four named states. In `W_IDLE` a write is decoded as a new command. `W_ARG` takes the operand of a two-cycle command: program data, erase confirm, lock argument, buffer count, or any byte while in query mode. `W_DATA` stores buffered words until the count is spent. `W_CONFIRM` waits for the closing confirm byte of a buffered write. Named transitions: *setup* (`W_IDLE`→`W_ARG`), *latch* (`W_IDLE` stays, command held), *bail* (any state→`W_IDLE` with the command cleared, so reads return the array), *finish* (`W_ARG`/`W_CONFIRM`→`W_IDLE` with the command kept, so reads return status), *count* (`W_ARG`→`W_DATA`), *last word* (`W_DATA`→`W_CONFIRM`). In `W_ARG` under query mode, any byte except 0xFF leaves the machine in `W_ARG` (*stay*).

An optional secure mode rejects non-secure writes and returns raw array data to non-secure reads. A read-only input turns program and erase into error reports.

Top module: `flash_seq`

## Requirements
- R1: After an active-low synchronous reset the status byte is 0x00, the write state is `W_IDLE`, reads return array data, and every array byte reads 0xFF.
- R2: In `W_IDLE`, a write whose low byte is 0x00, 0xF0, 0xFF or any unlisted value clears the latched command, so the next read returns array data.
- R3: A write of 0x70 (status) or 0x90 (identification) latches that command without leaving `W_IDLE`, so the next write is decoded as a fresh command.
- R4: A write of 0x50 in `W_IDLE` sets the whole status byte to 0x00 and returns to array reads.
- R5: After 0x10 or 0x40, the next write stores its data at its address and sets status bit 7. The machine returns to `W_IDLE`, and reads return status until an array-read command is written.
- R6: When `ro_i` is high, a program data write sets status bit 4 and an erase sets status bit 5. In both cases the array is left unchanged.
- R7: 0x20 fills with 0xFF the sector holding the address, a sector being 2^SECTOR_W bytes whose start has the low SECTOR_W address bits cleared, and sets bit 7. A following 0xD0 keeps status reads; any other byte returns to array reads.
- R8: After 0xE8 (sets bit 7), the next write gives a count masked to DEV_BYTES*8 bits. Exactly count+1 data writes follow and are stored. A final 0xD0 finishes with status reads, and any other final byte returns to array reads.
- R9: After 0x60, a byte of 0xD0 or 0x01 sets bit 7 and finishes with status reads; any other byte returns to array reads.
- R10: Status reads place the status byte in byte lane 0 and in every further lane starting at a multiple of DEV_BYTES that fits wholly inside the access; all other bytes are 0.
- R11: With index = address >> log2(BANK_BYTES), identification mode returns MAKER_ID at index 0, PART_ID at index 1 and 0 elsewhere. Query mode (0x98) returns 0x51, 0x52, 0x59 at indexes 0x10 to 0x12 and stays active until 0xFF is written. Both modes replicate lanes as in R10.
- R12: With SECURE_EN set, a write with `secure_i` low changes nothing and raises `err_o` for one cycle; a read with `secure_i` low returns array data in any mode.
- R13: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes at consecutive addresses. Little-endian puts the byte at address+i in bits [8i+7:8i]; big-endian puts the first byte in the top lane of the access.
- R14: `rdata_o` is loaded on the edge where `rd_i` is high and holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data or command byte in bits 7:0 |
| size_i | input | 2 | Access size code: 0=1, 1=2, 2=4 bytes |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| secure_i | input | 1 | Access is secure |
| ro_i | input | 1 | Device is read-only |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Rejected write, one cycle after it |

## Verification
Every write changes state, array and status on the clock edge that samples it, so its effect is visible to a read issued in the next cycle. Read data and the write-reject flag are registered once, so each is due one cycle after its strobe. The bench drives strobes at a falling edge and samples at the next falling edge, half a cycle after that register loads, and holds every strobe for exactly one cycle. A second instance built big-endian receives the same stimulus, so byte ordering is compared on the same writes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ARG,
        W_DATA,
        W_CONFIRM
    } wstate_e;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_STATUS,
        SRC_IDENT,
        SRC_QUERY
    } rsrc_e;

    localparam logic [7:0] OP_NOP       = 8'h00;
    localparam logic [7:0] OP_ARG_ONE   = 8'h01;
    localparam logic [7:0] OP_PROG_A    = 8'h10;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_ERASE_ALT = 8'h28;
    localparam logic [7:0] OP_PROG_B    = 8'h40;
    localparam logic [7:0] OP_CLEAR     = 8'h50;
    localparam logic [7:0] OP_LOCK      = 8'h60;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_QUERY     = 8'h98;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_BUFFER    = 8'hE8;
    localparam logic [7:0] OP_EXIT      = 8'hF0;
    localparam logic [7:0] OP_ARRAY     = 8'hFF;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ok,
    input  logic [CNT_W-1:0]    wdata,
    input  logic                ro,
    output wstate_e             wst_o,
    output logic [7:0]          cmd_o,
    output logic [7:0]          status_o,
    output logic                prog_o,
    output logic                erase_o
);

    wstate_e          wst_q, wst_n;
    logic [7:0]       cmd_q, cmd_n;
    logic [7:0]       stat_q, stat_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [7:0]       op;

    assign op = wdata[7:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst_q  <= W_IDLE;
            cmd_q  <= OP_NOP;
            stat_q <= 8'h00;
            cnt_q  <= '0;
        end else begin
            wst_q  <= wst_n;
            cmd_q  <= cmd_n;
            stat_q <= stat_n;
            cnt_q  <= cnt_n;
        end
    end

    always_comb begin
        wst_n   = wst_q;
        cmd_n   = cmd_q;
        stat_n  = stat_q;
        cnt_n   = cnt_q;
        prog_o  = 1'b0;
        erase_o = 1'b0;
        if (wr_ok) begin
            unique case (wst_q)
                W_IDLE: begin
                    case (op)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            wst_n = W_ARG;
                            cmd_n = op;
                        end
                        OP_ERASE: begin
                            wst_n = W_ARG;
                            cmd_n = op;
                            if (ro) stat_n[ST_ERASE_ERR] = 1'b1;
                            else    erase_o = 1'b1;
                            stat_n[ST_READY] = 1'b1;
                        end
                        OP_BUFFER: begin
                            wst_n = W_ARG;
                            cmd_n = op;
                            stat_n[ST_READY] = 1'b1;
                        end
                        OP_CLEAR: begin
                            stat_n = 8'h00;
                            cmd_n  = OP_NOP;
                        end
                        OP_STATUS, OP_IDENT: cmd_n = op;
                        default:             cmd_n = OP_NOP;
                    endcase
                end
                W_ARG: begin
                    wst_n = W_IDLE;
                    case (cmd_q)
                        OP_PROG_A, OP_PROG_B: begin
                            if (ro) stat_n[ST_PROG_ERR] = 1'b1;
                            else    prog_o = 1'b1;
                            stat_n[ST_READY] = 1'b1;
                        end
                        OP_ERASE: begin
                            if (op == OP_CONFIRM) stat_n[ST_READY] = 1'b1;
                            else                  cmd_n = OP_NOP;
                        end
                        OP_LOCK: begin
                            if (op == OP_CONFIRM || op == OP_ARG_ONE)
                                stat_n[ST_READY] = 1'b1;
                            else
                                cmd_n = OP_NOP;
                        end
                        OP_QUERY: begin
                            if (op == OP_ARRAY) cmd_n = OP_NOP;
                            else                wst_n = W_ARG;
                        end
                        OP_BUFFER: begin
                            cnt_n = wdata;
                            wst_n = W_DATA;
                        end
                        default: cmd_n = OP_NOP;
                    endcase
                end
                W_DATA: begin
                    if (ro) stat_n[ST_PROG_ERR] = 1'b1;
                    else    prog_o = 1'b1;
                    stat_n[ST_READY] = 1'b1;
                    if (cnt_q == '0) wst_n = W_CONFIRM;
                    cnt_n = cnt_q - 1'b1;
                end
                W_CONFIRM: begin
                    wst_n = W_IDLE;
                    if (op == OP_CONFIRM) stat_n[ST_READY] = 1'b1;
                    else                  cmd_n = OP_NOP;
                end
            endcase
        end
    end

    assign wst_o    = wst_q;
    assign cmd_o    = cmd_q;
    assign status_o = stat_q;

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SECTOR_W   = 5,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        size,
    input  logic              prog,
    input  logic              erase,
    output logic [31:0]       rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [2:0] nb;

    assign nb = size_bytes(size);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
        end else if (erase) begin
            for (int j = 0; j < DEPTH; j++) begin
                if ((ADDR_W'(j) >> SECTOR_W) == (addr >> SECTOR_W))
                    mem[j] <= 8'hFF;
            end
        end else if (prog) begin
            for (int i = 0; i < 4; i++) begin
                if (3'(i) < nb)
                    mem[addr + ADDR_W'(i)] <=
                        wdata[(BIG_ENDIAN ? (int'(nb) - 1 - i) : i) * 8 +: 8];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < nb)
                rdata[(BIG_ENDIAN ? (int'(nb) - 1 - i) : i) * 8 +: 8] =
                    mem[addr + ADDR_W'(i)];
        end
    end

endmodule

// File: rtl/flash_seq_rdmux.sv
module flash_seq_rdmux
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         SECTOR_W   = 5,
    parameter int         BANK_BYTES = 4,
    parameter int         DEV_BYTES  = 2,
    parameter logic [7:0] MAKER_ID   = 8'h89,
    parameter logic [7:0] PART_ID    = 8'h18
) (
    input  rsrc_e             src,
    input  logic [7:0]        status,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       array_data,
    output logic [31:0]       rdata
);

    localparam int BANK_SH = $clog2(BANK_BYTES);
    localparam logic [7:0] SECT_LAST = 8'((1 << (ADDR_W - SECTOR_W)) - 1);

    logic [ADDR_W-1:0] idx;
    logic [7:0]        qbyte, ibyte, lane_val;
    logic [2:0]        nb;

    assign idx = addr >> BANK_SH;
    assign nb  = size_bytes(size);

    always_comb begin
        case (idx)
            ADDR_W'('h10): qbyte = 8'h51;
            ADDR_W'('h11): qbyte = 8'h52;
            ADDR_W'('h12): qbyte = 8'h59;
            ADDR_W'('h13): qbyte = 8'h01;
            ADDR_W'('h27): qbyte = 8'(ADDR_W);
            ADDR_W'('h2C): qbyte = 8'h01;
            ADDR_W'('h2D): qbyte = SECT_LAST;
            default:       qbyte = 8'h00;
        endcase
    end

    always_comb begin
        case (idx)
            ADDR_W'(0): ibyte = MAKER_ID;
            ADDR_W'(1): ibyte = PART_ID;
            default:    ibyte = 8'h00;
        endcase
    end

    always_comb begin
        case (src)
            SRC_STATUS: lane_val = status;
            SRC_IDENT:  lane_val = ibyte;
            default:    lane_val = qbyte;
        endcase
    end

    always_comb begin
        if (src == SRC_ARRAY) begin
            rdata = array_data;
        end else begin
            rdata = '0;
            for (int b = 0; b < 4; b++) begin
                if (b == 0 || ((b % DEV_BYTES) == 0 && (b + DEV_BYTES) <= int'(nb)))
                    rdata[b*8 +: 8] = lane_val;
            end
        end
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         SECTOR_W   = 5,
    parameter int         BANK_BYTES = 4,
    parameter int         DEV_BYTES  = 2,
    parameter bit         BIG_ENDIAN = 1'b0,
    parameter bit         SECURE_EN  = 1'b1,
    parameter logic [7:0] MAKER_ID   = 8'h89,
    parameter logic [7:0] PART_ID    = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [1:0]        size_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              secure_i,
    input  logic              ro_i,
    output logic [31:0]       rdata_o,
    output logic              err_o
);

    localparam int CNT_W = DEV_BYTES * 8;

    wstate_e     wst;
    logic [7:0]  cmd;
    logic [7:0]  status;
    logic        prog, erase;
    logic        trusted, wr_ok;
    rsrc_e       src;
    logic [31:0] array_data, mux_data;
    logic [31:0] rdata_q;
    logic        err_q;

    assign trusted = !SECURE_EN || secure_i;
    assign wr_ok   = wr_i && trusted;

    flash_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wdata    (wdata_i[CNT_W-1:0]),
        .ro       (ro_i),
        .wst_o    (wst),
        .cmd_o    (cmd),
        .status_o (status),
        .prog_o   (prog),
        .erase_o  (erase)
    );

    flash_seq_array #(
        .ADDR_W     (ADDR_W),
        .SECTOR_W   (SECTOR_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_i),
        .wdata (wdata_i),
        .size  (size_i),
        .prog  (prog),
        .erase (erase),
        .rdata (array_data)
    );

    always_comb begin
        if (!trusted) begin
            src = SRC_ARRAY;
        end else begin
            case (cmd)
                OP_PROG_A, OP_ERASE, OP_ERASE_ALT, OP_PROG_B,
                OP_CLEAR, OP_LOCK, OP_STATUS, OP_BUFFER: src = SRC_STATUS;
                OP_IDENT: src = SRC_IDENT;
                OP_QUERY: src = SRC_QUERY;
                default:  src = SRC_ARRAY;
            endcase
        end
    end

    flash_seq_rdmux #(
        .ADDR_W     (ADDR_W),
        .SECTOR_W   (SECTOR_W),
        .BANK_BYTES (BANK_BYTES),
        .DEV_BYTES  (DEV_BYTES),
        .MAKER_ID   (MAKER_ID),
        .PART_ID    (PART_ID)
    ) u_rdmux (
        .src        (src),
        .status     (status),
        .addr       (addr_i),
        .size       (size_i),
        .array_data (array_data),
        .rdata      (mux_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd_i) rdata_q <= mux_data;
            err_q <= wr_i && !trusted;
        end
    end

    assign rdata_o = rdata_q;
    assign err_o   = err_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
    import flash_seq_pkg::*;
#(
    parameter bit SECURE_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic        secure_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] rdata_o,
    input  logic        err_o,
    input  wstate_e     wst,
    input  logic [7:0]  cmd,
    input  logic [7:0]  status
);

    logic ok;
    assign ok = !SECURE_EN || secure_i;

    // R1: leaving reset finds an idle machine and a clear status byte
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 8'h00 && wst == W_IDLE));

    // R3: status/ident latch keeps the machine idle
    p_latch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ok && wst == W_IDLE && (wdata_i[7:0] == 8'h70 || wdata_i[7:0] == 8'h90))
        |=> (wst == W_IDLE && cmd == $past(wdata_i[7:0])));

    // R4: clear command empties status
    p_clear_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ok && wst == W_IDLE && wdata_i[7:0] == 8'h50) |=> (status == 8'h00));

    // R5: program data write ends ready and idle
    p_prog_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ok && wst == W_ARG && (cmd == 8'h10 || cmd == 8'h40))
        |=> (status[7] && wst == W_IDLE));

    // R10: status read returns the status byte in lane 0
    p_status_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ok && cmd == 8'h70) |=> (rdata_o[7:0] == $past(status)));

    // R12: rejected writes flag an error, accepted ones do not
    p_reject_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ok) |=> err_o);
    p_accept_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && !ok)) |=> !err_o);

    // R14: read data holds without a read strobe
    p_hold_rdata_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && $past(rst_n)) |=> $stable(rdata_o));

endmodule

bind flash_seq flash_seq_chk #(.SECURE_EN(SECURE_EN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .secure_i (secure_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .wst      (wst),
    .cmd      (cmd),
    .status   (status)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  size = '0;
    logic        wr = 1'b0, rd = 1'b0, sec = 1'b1, ro = 1'b0;
    logic [31:0] rdata_le, rdata_be;
    logic        err_le, err_be;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
        .wr_i(wr), .rd_i(rd), .secure_i(sec), .ro_i(ro),
        .rdata_o(rdata_le), .err_o(err_le)
    );

    flash_seq #(.BIG_ENDIAN(1'b1)) uut_be (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
        .wr_i(wr), .rd_i(rd), .secure_i(sec), .ro_i(ro),
        .rdata_o(rdata_be), .err_o(err_be)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s,
                          input logic sc, output logic e);
        @(negedge clk);
        addr = a; wdata = d; size = s; sec = sc; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; e = err_le; sec = 1'b1;
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
        logic e;
        wr_cyc(a, d, s, 1'b1, e);
    endtask

    task automatic op(input logic [7:0] c);
        put(8'h00, {24'h0, c}, 2'd0);
    endtask

    task automatic get(input logic [7:0] a, input logic [1:0] s, input logic sc,
                       output logic [31:0] d);
        @(negedge clk);
        addr = a; size = s; sec = sc; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; sec = 1'b1; d = rdata_le;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] a, input logic [1:0] s,
                             input logic [31:0] exp);
        logic [31:0] d;
        get(a, s, 1'b1, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        expect_rd("R1 erased array after reset", 8'h00, 2'd2, 32'hFFFF_FFFF);
        op(8'h70);
        expect_rd("R1 status zero after reset", 8'h00, 2'd2, 32'h0);
        op(8'hFF);
    endtask

    task automatic t_program;
        op(8'h40);
        put(8'h20, 32'h1122_3344, 2'd2);
        expect_rd("R5 R10 status after program, 4-byte", 8'h00, 2'd2, 32'h0080_0080);
        expect_rd("R10 status 2-byte lane", 8'h00, 2'd1, 32'h0000_0080);
        op(8'hFF);
        expect_rd("R5 stored word", 8'h20, 2'd2, 32'h1122_3344);
        expect_rd("R13 single byte at +1", 8'h21, 2'd0, 32'h0000_0033);
        expect_rd("R13 halfword at +2", 8'h22, 2'd1, 32'h0000_1122);
        get(8'h20, 2'd0, 1'b1, rdata_le);
        check("R13 little-endian first byte", rdata_le, 32'h44);
        check("R13 big-endian first byte", rdata_be, 32'h11);
        check("R13 big-endian instance", rdata_be, 32'h0000_0011);
        op(8'h10);
        put(8'h30, 32'h0000_005A, 2'd0);
        op(8'hFF);
        expect_rd("R5 byte program via 0x10", 8'h30, 2'd0, 32'h5A);
        op(8'h40);
        put(8'h40, 32'hCAFE_BABE, 2'd2);
        op(8'hFF);
        expect_rd("R5 second word", 8'h40, 2'd2, 32'hCAFE_BABE);
    endtask

    task automatic t_clear;
        op(8'h50);
        expect_rd("R4 clear returns to array", 8'h20, 2'd2, 32'h1122_3344);
        op(8'h70);
        expect_rd("R4 status cleared", 8'h00, 2'd2, 32'h0);
        op(8'hFF);
    endtask

    task automatic t_latch;
        op(8'h90);
        expect_rd("R3 ident latched", 8'h00, 2'd0, 32'h89);
        op(8'h70);
        expect_rd("R3 next write decoded as command", 8'h00, 2'd0, 32'h00);
        op(8'hFF);
    endtask

    task automatic t_reset_cmds;
        logic [7:0] codes [4] = '{8'hF0, 8'h00, 8'hAB, 8'hFF};
        for (int k = 0; k < 4; k++) begin
            op(8'h70);
            op(codes[k]);
            expect_rd($sformatf("R2 byte %h returns to array", codes[k]), 8'h40, 2'd2, 32'hCAFE_BABE);
        end
    endtask

    task automatic t_erase;
        put(8'h3C, 32'h20, 2'd0);
        put(8'h3C, 32'hD0, 2'd0);
        expect_rd("R7 confirm keeps status", 8'h00, 2'd0, 32'h80);
        op(8'hFF);
        expect_rd("R7 sector word erased", 8'h20, 2'd2, 32'hFFFF_FFFF);
        expect_rd("R7 sector byte erased", 8'h30, 2'd0, 32'hFF);
        expect_rd("R7 other sector kept", 8'h40, 2'd2, 32'hCAFE_BABE);
        put(8'h80, 32'h20, 2'd0);
        put(8'h80, 32'h33, 2'd0);
        expect_rd("R7 bad confirm returns to array", 8'h40, 2'd2, 32'hCAFE_BABE);
    endtask

    task automatic t_buffer;
        put(8'h60, 32'hE8, 2'd0);
        put(8'h60, 32'h0001_0002, 2'd2);
        put(8'h60, 32'hA000_0001, 2'd2);
        put(8'h64, 32'hA000_0002, 2'd2);
        put(8'h68, 32'hA000_0003, 2'd2);
        put(8'h6C, 32'h0000_00D0, 2'd2);
        expect_rd("R8 confirm gives status", 8'h00, 2'd0, 32'h80);
        op(8'hFF);
        expect_rd("R8 word 0", 8'h60, 2'd2, 32'hA000_0001);
        expect_rd("R8 word 1", 8'h64, 2'd2, 32'hA000_0002);
        expect_rd("R8 word 2", 8'h68, 2'd2, 32'hA000_0003);
        expect_rd("R8 count masked, no extra word", 8'h6C, 2'd2, 32'hFFFF_FFFF);
        put(8'h70, 32'hE8, 2'd0);
        put(8'h70, 32'h0, 2'd2);
        put(8'h70, 32'h0BAD_F00D, 2'd2);
        put(8'h74, 32'h55, 2'd0);
        expect_rd("R8 bad confirm returns to array", 8'h70, 2'd2, 32'h0BAD_F00D);
    endtask

    task automatic t_lock;
        op(8'h50);
        op(8'h60); op(8'h01);
        expect_rd("R9 lock arg 0x01", 8'h00, 2'd0, 32'h80);
        op(8'hFF);
        op(8'h50);
        op(8'h60); op(8'hD0);
        expect_rd("R9 lock arg 0xD0", 8'h00, 2'd0, 32'h80);
        op(8'hFF);
        op(8'h60); op(8'h77);
        expect_rd("R9 bad lock arg to array", 8'h40, 2'd2, 32'hCAFE_BABE);
    endtask

    task automatic t_query;
        op(8'h98);
        expect_rd("R11 query Q", 8'h40, 2'd0, 32'h51);
        expect_rd("R11 query R replicated", 8'h44, 2'd2, 32'h0052_0052);
        op(8'h00);
        expect_rd("R11 query persists", 8'h48, 2'd0, 32'h59);
        op(8'hFF);
        expect_rd("R11 query exit", 8'h40, 2'd2, 32'hCAFE_BABE);
        op(8'h90);
        expect_rd("R11 maker id", 8'h00, 2'd0, 32'h89);
        expect_rd("R11 part id replicated", 8'h04, 2'd2, 32'h0018_0018);
        expect_rd("R11 other index zero", 8'h08, 2'd0, 32'h00);
        op(8'hFF);
    endtask

    task automatic t_ro;
        op(8'h50);
        ro = 1'b1;
        op(8'h40);
        put(8'h40, 32'h0102_0304, 2'd2);
        expect_rd("R6 program error bit", 8'h00, 2'd0, 32'h90);
        op(8'hFF);
        expect_rd("R6 program blocked", 8'h40, 2'd2, 32'hCAFE_BABE);
        op(8'h50);
        put(8'h40, 32'h20, 2'd0);
        put(8'h40, 32'hD0, 2'd0);
        expect_rd("R6 erase error bit", 8'h00, 2'd0, 32'hA0);
        op(8'hFF);
        expect_rd("R6 erase blocked", 8'h40, 2'd2, 32'hCAFE_BABE);
        ro = 1'b0;
    endtask

    task automatic t_secure;
        logic e;
        logic [31:0] d;
        wr_cyc(8'h00, 32'h70, 2'd0, 1'b1, e);
        check("R12 secure write no error", {31'h0, e}, 32'h0);
        wr_cyc(8'h00, 32'h50, 2'd0, 1'b0, e);
        check("R12 non-secure write error", {31'h0, e}, 32'h1);
        expect_rd("R12 rejected clear had no effect", 8'h00, 2'd0, 32'hA0);
        get(8'h40, 2'd2, 1'b0, d);
        check("R12 non-secure read raw array", d, 32'hCAFE_BABE);
        op(8'hFF);
    endtask

    task automatic t_hold;
        expect_rd("R14 read loads", 8'h40, 2'd2, 32'hCAFE_BABE);
        @(negedge clk);
        addr = 8'h60;
        @(negedge clk);
        check("R14 data holds without strobe", rdata_le, 32'hCAFE_BABE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_clear();
        t_latch();
        t_reset_cmds();
        t_erase();
        t_buffer();
        t_lock();
        t_query();
        t_ro();
        t_secure();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule